// File: doc/BRIEF.md
# Scoreboard In-Order Issue Control

This block gates issue for the oldest instruction of an in-order stream. It keeps one pending-write bit per general-purpose register. A bit that is set means an instruction already in flight has yet to write that register. Each cycle the block takes the decoded destination and two source indices of the head instruction, the functional unit that instruction targets, and the busy flags of all units. From these it decides whether the instruction goes out now or waits. Because issue is in order, a waiting head holds back everything behind it. The block only says "wait"; the upstream pipeline holds the head instruction.

Results come back from the functional units over several writeback ports, in any order. Each writeback clears the pending bit of its register. A clear that arrives in the same cycle as the check counts in that check, so a dependent instruction can issue in the same cycle that its operand is written back. Register 0 is a constant register and is never marked pending. Unused source or destination fields should therefore point at register 0.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset all pending bits are clear, so any valid instruction whose target unit is idle issues in the first cycle.
- R2: A valid instruction stalls (issue_o=0, stall_o=1) when the pending bit of src_a_i or src_b_i is set (read-after-write).
- R3: A valid instruction stalls when the pending bit of dst_i is set (write-after-write).
- R4: A valid instruction stalls when fu_busy_i[fu_sel_i] is 1, where bit k of fu_busy_i is the busy flag of unit k.
- R5: When an instruction issues with a nonzero dst_i, that register's pending bit is set from the next cycle on. A stalled or invalid instruction sets no bit.
- R6: A writeback on any port (wb_valid_i[k]=1, register wb_reg_i[k]) clears that register's pending bit. Writebacks may come in any order relative to issue order.
- R7: A writeback in the same cycle as a check makes that check see the register as not pending.
- R8: Register 0 is never pending. Writing it as a destination sets nothing, and reading it as a source never stalls.
- R9: stall_o is 1 exactly when instr_valid_i is 1 and issue_o is 0. With instr_valid_i=0 both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | The head instruction is present |
| dst_i | input | IDX_W | Destination register index |
| src_a_i | input | IDX_W | First source register index |
| src_b_i | input | IDX_W | Second source register index |
| fu_sel_i | input | FU_W | Functional unit the head instruction targets |
| fu_busy_i | input | NUM_FU | Busy flag for each functional unit |
| wb_valid_i | input | NUM_WB | A writeback is present on port k |
| wb_reg_i | input | NUM_WB*IDX_W | Register written back on port k |
| issue_o | output | 1 | The head instruction issues this cycle |
| stall_o | output | 1 | The head instruction is present but must wait |

## Verification
Some rules are checked by assertions on every cycle:
- register 0 never becomes pending;
- an issue always sets the pending bit of its destination in the next cycle;
- a pending bit never rises unless an issue caused it;
- no issue goes to a busy unit.

Other behaviour shows up only in the bench scenarios, which drive the same stimulus into a behavioural model and compare with the design on every cycle. These cover:
- stalls on each hazard kind (source, destination and busy unit);
- out-of-order clears;
- the same-cycle clear and issue case;
- the random mixed traffic.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SB_NUM_REGS = 32;
  localparam int unsigned SB_NUM_FU   = 4;
  localparam int unsigned SB_NUM_WB   = 2;
endpackage

// File: rtl/sb_clear_decode.sv
module sb_clear_decode #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned NUM_WB   = 2,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_WB-1:0]            wb_valid_i,
  input  logic [NUM_WB-1:0][IDX_W-1:0] wb_reg_i,
  output logic [NUM_REGS-1:0]          clr_mask_o
);
  logic [NUM_WB-1:0][NUM_REGS-1:0] port_mask;

  for (genvar k = 0; k < NUM_WB; k++) begin : g_port
    always_comb begin
      port_mask[k] = '0;
      if (wb_valid_i[k]) port_mask[k][wb_reg_i[k]] = 1'b1;
    end
  end

  always_comb begin
    clr_mask_o = '0;
    for (int k = 0; k < NUM_WB; k++) clr_mask_o = clr_mask_o | port_mask[k];
  end
endmodule

// File: rtl/sb_bit_array.sv
module sb_bit_array #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] clr_mask_i,
  input  logic                set_en_i,
  input  logic [IDX_W-1:0]    set_idx_i,
  output logic [NUM_REGS-1:0] busy_o
);
  logic [NUM_REGS-1:0] busy_q, set_mask, busy_d;

  always_comb begin
    set_mask = '0;
    if (set_en_i && set_idx_i != '0) set_mask[set_idx_i] = 1'b1;
    // set wins over a same-cycle clear of the same register
    busy_d = (busy_q & ~clr_mask_i) | set_mask;
    busy_d[0] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= busy_d;
  end

  assign busy_o = busy_q;

  // R8
  r0_never_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q[0] == 1'b0);

  // R5
  set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i && set_idx_i != '0) |=> busy_q[$past(set_idx_i)]);

  // R5
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_en_i |=> ((busy_q & ~$past(busy_q)) == '0));
endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned NUM_FU   = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned FU_W    = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input  logic                instr_valid_i,
  input  logic [NUM_REGS-1:0] pend_i,
  input  logic [IDX_W-1:0]    dst_i,
  input  logic [IDX_W-1:0]    src_a_i,
  input  logic [IDX_W-1:0]    src_b_i,
  input  logic [FU_W-1:0]     fu_sel_i,
  input  logic [NUM_FU-1:0]   fu_busy_i,
  output logic                issue_o
);
  logic raw_hz, waw_hz, fu_hz;

  always_comb begin
    raw_hz = pend_i[src_a_i] | pend_i[src_b_i];
    waw_hz = pend_i[dst_i];
    fu_hz  = fu_busy_i[fu_sel_i];
    issue_o = instr_valid_i & ~raw_hz & ~waw_hz & ~fu_hz;
  end
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl #(
  parameter int unsigned NUM_REGS = sb_pkg::SB_NUM_REGS,
  parameter int unsigned NUM_FU   = sb_pkg::SB_NUM_FU,
  parameter int unsigned NUM_WB   = sb_pkg::SB_NUM_WB,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned FU_W    = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         instr_valid_i,
  input  logic [IDX_W-1:0]             dst_i,
  input  logic [IDX_W-1:0]             src_a_i,
  input  logic [IDX_W-1:0]             src_b_i,
  input  logic [FU_W-1:0]              fu_sel_i,
  input  logic [NUM_FU-1:0]            fu_busy_i,
  input  logic [NUM_WB-1:0]            wb_valid_i,
  input  logic [NUM_WB-1:0][IDX_W-1:0] wb_reg_i,
  output logic                         issue_o,
  output logic                         stall_o
);
  logic [NUM_REGS-1:0] clr_mask, busy, pend;
  logic issue;

  sb_clear_decode #(.NUM_REGS(NUM_REGS), .NUM_WB(NUM_WB)) u_clr (
    .wb_valid_i (wb_valid_i),
    .wb_reg_i   (wb_reg_i),
    .clr_mask_o (clr_mask)
  );

  sb_bit_array #(.NUM_REGS(NUM_REGS)) u_bits (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_mask_i (clr_mask),
    .set_en_i   (issue),
    .set_idx_i  (dst_i),
    .busy_o     (busy)
  );

  // same-cycle writeback bypasses the check
  assign pend = busy & ~clr_mask;

  sb_hazard_check #(.NUM_REGS(NUM_REGS), .NUM_FU(NUM_FU)) u_hz (
    .instr_valid_i (instr_valid_i),
    .pend_i        (pend),
    .dst_i         (dst_i),
    .src_a_i       (src_a_i),
    .src_b_i       (src_b_i),
    .fu_sel_i      (fu_sel_i),
    .fu_busy_i     (fu_busy_i),
    .issue_o       (issue)
  );

  assign issue_o = issue;
  assign stall_o = instr_valid_i & ~issue;

  // R4
  no_busy_fu_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> !fu_busy_i[fu_sel_i]);

  // R3
  no_waw_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && dst_i != '0) |-> (!busy[dst_i] || clr_mask[dst_i]));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |-> (!issue_o && !stall_o));
endmodule

// File: tb/tb_sb_issue_ctrl.sv
`timescale 1ns/1ps
module tb_sb_issue_ctrl;
  localparam int NR = 32;
  localparam int NF = 4;

  logic clk = 0, rst_ni = 0;
  logic instr_valid_i = 0;
  logic [4:0] dst_i = 0, src_a_i = 0, src_b_i = 0;
  logic [1:0] fu_sel_i = 0;
  logic [NF-1:0] fu_busy_i = 0;
  logic [1:0] wb_valid_i = 0;
  logic [1:0][4:0] wb_reg_i = '0;
  logic issue_o, stall_o;

  int checks = 0, errors = 0;
  bit mdl [NR];

  always #2.5 clk = ~clk;

  sb_issue_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_valid_i(instr_valid_i),
    .dst_i(dst_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .fu_sel_i(fu_sel_i), .fu_busy_i(fu_busy_i),
    .wb_valid_i(wb_valid_i), .wb_reg_i(wb_reg_i),
    .issue_o(issue_o), .stall_o(stall_o)
  );

  function automatic bit pend(int r);
    if (r == 0) return 0;
    if (wb_valid_i[0] && wb_reg_i[0] == r) return 0;
    if (wb_valid_i[1] && wb_reg_i[1] == r) return 0;
    return mdl[r];
  endfunction

  task automatic step(input bit v, input int d, input int a, input int b,
                      input int fu, input int fb, input bit w0, input int r0,
                      input bit w1, input int r1, input string tag,
                      input int must = -1);
    bit exp_iss, exp_stl;
    @(negedge clk);
    instr_valid_i = v; dst_i = 5'(d); src_a_i = 5'(a); src_b_i = 5'(b);
    fu_sel_i = 2'(fu); fu_busy_i = 4'(fb);
    wb_valid_i = {w1, w0}; wb_reg_i[0] = 5'(r0); wb_reg_i[1] = 5'(r1);
    #1;
    exp_iss = v && !pend(a) && !pend(b) && !pend(d) && !fu_busy_i[fu];
    exp_stl = v && !exp_iss;
    checks++;
    if (issue_o !== exp_iss || stall_o !== exp_stl) begin
      errors++;
      $display("FAIL %s: issue/stall actual %b%b expected %b%b", tag, issue_o, stall_o, exp_iss, exp_stl);
    end
    if (must >= 0) begin
      checks++;
      if (exp_iss !== bit'(must)) begin
        errors++;
        $display("FAIL %s: scenario model issue actual %b expected %0d", tag, exp_iss, must);
      end
    end
    @(posedge clk);
    if (w0) mdl[r0] = 0;
    if (w1) mdl[r1] = 0;
    if (exp_iss && d != 0) mdl[d] = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: timeout actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    foreach (mdl[i]) mdl[i] = 0;
    #12 rst_ni = 1;
    // R1 first instruction after reset issues
    step(1, 3, 1, 2, 0, 0, 0, 0, 0, 0, "R1", 1);
    // R5 + R3 dst 3 now pending
    step(1, 3, 0, 0, 1, 0, 0, 0, 0, 0, "R3", 0);
    // R2 source a and b
    step(1, 4, 3, 0, 1, 0, 0, 0, 0, 0, "R2a", 0);
    step(1, 4, 0, 3, 1, 0, 0, 0, 0, 0, "R2b", 0);
    // R9 idle: nothing sets
    step(0, 5, 0, 0, 0, 0, 0, 0, 0, 0, "R9", 0);
    step(1, 6, 5, 5, 0, 0, 0, 0, 0, 0, "R9_noset", 1);
    // R4 busy unit; stalled does not set (R5)
    step(1, 7, 0, 0, 2, 4'b0100, 0, 0, 0, 0, "R4", 0);
    step(1, 8, 7, 7, 2, 4'b1011, 0, 0, 0, 0, "R5_stallnoset", 1);
    // R6 out-of-order clear: 8 cleared before 6 and 3
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 8, "R6_clr");
    step(1, 9, 8, 0, 0, 0, 0, 0, 0, 0, "R6", 1);
    step(1, 9, 6, 0, 0, 0, 0, 0, 0, 0, "R6_still", 0);
    // R7 same-cycle clear on port 0 and port 1
    step(1, 10, 6, 3, 3, 0, 1, 6, 1, 3, "R7", 1);
    step(1, 9, 0, 0, 0, 0, 1, 9, 0, 0, "R7_waw", 1);
    // R8 register 0
    step(1, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R8_dst", 1);
    step(1, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R8", 1);
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 15) & 4'b0101,
           $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 1),
           $urandom_range(0, 7), "R6_R7_rnd");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule